// File: doc/BRIEF.md
# Scaler Operating Mode Selector

This block picks the processing mode of a display scaler. It looks at the class of the incoming pixel format and at the four scaling ratios: luma horizontal, luma vertical, chroma horizontal and chroma vertical. From these it produces a 3-bit mode code. The format class arrives as three flags: half-precision floating point, 4:2:0 subsampled, and video (YCbCr). Two control bits shape the decision. One says that the pipeline works in fixed point. The other forces scaling even when every ratio is one.

The ratios are unsigned 3.19 fixed-point values. A ratio counts as unity only when it equals exactly 1.0, which is the value 1 shifted left by 19. The decision is a fixed priority tree. A floating-point source in a fixed-point pipeline bypasses the whole scaler. Otherwise, an all-unity set of ratios without forced scaling bypasses the 4:4:4 scaling path. Otherwise, non-4:2:0 sources pick RGB or YCbCr scaling. Finally, 4:2:0 sources pick one of three modes: luma-only bypass, chroma-only bypass or full 4:2:0 scaling.

The mode code is captured on a load strobe and is held between strobes. Configuration logic pulses the strobe once the format and the ratios are stable.

Top module: `scl_mode_sel`

## Requirements
- R1: After reset the mode output reads 0. At all times it is one of the seven codes 0 to 6 and never 7.
- R2: When the fixed-point capability bit and the floating-point format flag are both set at a load, the mode becomes 6, whatever the ratios, the other flags and the force bit are.
- R3: When the fixed-point capability bit is clear, the floating-point flag has no effect, and the mode follows the same rules as for a source with that flag clear.
- R4: If R2 does not apply, all four ratios are unity and the force bit is clear at a load, the mode becomes 0 (4:4:4 scaling bypass).
- R5: If neither R2 nor R4 applies and the 4:2:0 flag is clear, the mode becomes 2 (4:4:4 YCbCr scaling) when the video flag is set, and 1 (4:4:4 RGB scaling) otherwise.
- R6: If neither R2 nor R4 applies, the 4:2:0 flag is set and both luma ratios are unity, the mode becomes 4 (4:2:0 luma bypass).
- R7: If neither R2 nor R4 applies, the 4:2:0 flag is set and the luma ratios are not both unity, the mode becomes 5 (4:2:0 chroma bypass) when both chroma ratios are unity, and 3 (4:2:0 YCbCr scaling) otherwise.
- R8: A ratio is unity only when it equals 0x80000 exactly. A ratio one LSB above or below that value, or 2.0, counts as non-unity.
- R9: The mode output takes its new value on the first rising clock edge at which the load strobe is high. It keeps its value on every edge without the strobe, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Capture strobe for a new mode |
| fixed_cap_i | input | 1 | Pipeline processes data in fixed point |
| fmt_fp16_i | input | 1 | Source is half-precision floating point |
| fmt_420_i | input | 1 | Source is 4:2:0 subsampled |
| fmt_video_i | input | 1 | Source is a video (YCbCr) format |
| force_scale_i | input | 1 | Force scaling even with unity ratios |
| ratio_luma_h_i | input | 22 | Luma horizontal ratio, unsigned 3.19 |
| ratio_luma_v_i | input | 22 | Luma vertical ratio, unsigned 3.19 |
| ratio_chroma_h_i | input | 22 | Chroma horizontal ratio, unsigned 3.19 |
| ratio_chroma_v_i | input | 22 | Chroma vertical ratio, unsigned 3.19 |
| mode_o | output | 3 | Registered mode code |

## Verification
Several decision branches can be true for the same load. The floating-point bypass can coincide with an all-unity ratio set. On a 4:2:0 source, unity luma ratios and unity chroma ratios can both hold at once. A sweep over every flag combination, with each ratio set to unity, one LSB off unity or 2.0, brings these overlaps about. Each result is compared with a priority-ordered model in the bench, so a wrong winner is caught. The sweep also changes the inputs without a strobe and checks that the captured code does not move.

// File: rtl/scl_mode_pkg.sv
package scl_mode_pkg;

    typedef enum logic [2:0] {
        MODE_BYP444     = 3'd0,
        MODE_RGB444     = 3'd1,
        MODE_YUV444     = 3'd2,
        MODE_YUV420     = 3'd3,
        MODE_LUMA_BYP   = 3'd4,
        MODE_CHROMA_BYP = 3'd5,
        MODE_FULL_BYP   = 3'd6
    } scl_mode_e;

    // Ratio slot order inside the unity vector
    localparam int unsigned SLOT_LUMA_H   = 0;
    localparam int unsigned SLOT_LUMA_V   = 1;
    localparam int unsigned SLOT_CHROMA_H = 2;
    localparam int unsigned SLOT_CHROMA_V = 3;
    localparam int unsigned NUM_RATIOS    = 4;

    typedef struct packed {
        scl_mode_e mode;
    } mode_state_t;

endpackage

// File: rtl/scl_ratio_unity.sv
module scl_ratio_unity #(
    parameter int unsigned INT_W  = 3,
    parameter int unsigned FRAC_W = 19
) (
    input  logic [INT_W+FRAC_W-1:0] ratio_i,
    output logic                    is_one_o
);
    localparam int unsigned W = INT_W + FRAC_W;
    localparam logic [W-1:0] ONE = W'(1) << FRAC_W;

    // Exact equality only: no tolerance band around 1.0
    always_comb begin
        is_one_o = (ratio_i == ONE);
    end
endmodule

// File: rtl/scl_mode_decide.sv
module scl_mode_decide
    import scl_mode_pkg::*;
(
    input  logic                  fixed_cap_i,
    input  logic                  fmt_fp16_i,
    input  logic                  fmt_420_i,
    input  logic                  fmt_video_i,
    input  logic                  force_scale_i,
    input  logic [NUM_RATIOS-1:0] unity_i,
    output scl_mode_e             mode_o
);
    logic luma_one;
    logic chroma_one;
    logic all_one;
    logic float_byp;

    always_comb begin
        luma_one   = unity_i[SLOT_LUMA_H] & unity_i[SLOT_LUMA_V];
        chroma_one = unity_i[SLOT_CHROMA_H] & unity_i[SLOT_CHROMA_V];
        all_one    = luma_one & chroma_one;
        float_byp  = fixed_cap_i & fmt_fp16_i;

        if (float_byp) begin
            mode_o = MODE_FULL_BYP;
        end else if (all_one && !force_scale_i) begin
            mode_o = MODE_BYP444;
        end else if (!fmt_420_i) begin
            mode_o = fmt_video_i ? MODE_YUV444 : MODE_RGB444;
        end else if (luma_one) begin
            mode_o = MODE_LUMA_BYP;
        end else if (chroma_one) begin
            mode_o = MODE_CHROMA_BYP;
        end else begin
            mode_o = MODE_YUV420;
        end
    end
endmodule

// File: rtl/scl_mode_sel.sv
module scl_mode_sel
    import scl_mode_pkg::*;
#(
    parameter int unsigned RATIO_INT_W  = 3,
    parameter int unsigned RATIO_FRAC_W = 19
) (
    input  logic                              clk_i,
    input  logic                              rst_ni,
    input  logic                              load_i,
    input  logic                              fixed_cap_i,
    input  logic                              fmt_fp16_i,
    input  logic                              fmt_420_i,
    input  logic                              fmt_video_i,
    input  logic                              force_scale_i,
    input  logic [RATIO_INT_W+RATIO_FRAC_W-1:0] ratio_luma_h_i,
    input  logic [RATIO_INT_W+RATIO_FRAC_W-1:0] ratio_luma_v_i,
    input  logic [RATIO_INT_W+RATIO_FRAC_W-1:0] ratio_chroma_h_i,
    input  logic [RATIO_INT_W+RATIO_FRAC_W-1:0] ratio_chroma_v_i,
    output logic [2:0]                        mode_o
);
    localparam int unsigned RW = RATIO_INT_W + RATIO_FRAC_W;
    localparam logic [RW-1:0] RATIO_ONE = RW'(1) << RATIO_FRAC_W;

    logic [RW-1:0]         ratio_arr [NUM_RATIOS];
    logic [NUM_RATIOS-1:0] unity;
    scl_mode_e             mode_next;
    mode_state_t           state_d, state_q;

    always_comb begin
        ratio_arr[SLOT_LUMA_H]   = ratio_luma_h_i;
        ratio_arr[SLOT_LUMA_V]   = ratio_luma_v_i;
        ratio_arr[SLOT_CHROMA_H] = ratio_chroma_h_i;
        ratio_arr[SLOT_CHROMA_V] = ratio_chroma_v_i;
    end

    for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_unity
        scl_ratio_unity #(
            .INT_W  (RATIO_INT_W),
            .FRAC_W (RATIO_FRAC_W)
        ) unity_i (
            .ratio_i  (ratio_arr[g]),
            .is_one_o (unity[g])
        );
    end

    scl_mode_decide decide_i (
        .fixed_cap_i   (fixed_cap_i),
        .fmt_fp16_i    (fmt_fp16_i),
        .fmt_420_i     (fmt_420_i),
        .fmt_video_i   (fmt_video_i),
        .force_scale_i (force_scale_i),
        .unity_i       (unity),
        .mode_o        (mode_next)
    );

    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d.mode = mode_next;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '{mode: MODE_BYP444};
        end else begin
            state_q <= state_d;
        end
    end

    assign mode_o = state_q.mode;

    // R1
    legal_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_o != 3'd7);

    // R9
    hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> $stable(mode_o));

    // R2
    full_byp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i && fixed_cap_i && fmt_fp16_i |=> mode_o == 3'd6);

    // R4
    all_unity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i && !(fixed_cap_i && fmt_fp16_i) && (&unity) && !force_scale_i
        |=> mode_o == 3'd0);

    // R5
    non420_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i && !(fixed_cap_i && fmt_fp16_i) && !fmt_420_i
        && !((&unity) && !force_scale_i)
        |=> mode_o == ($past(fmt_video_i) ? 3'd2 : 3'd1));

    // R8
    unity_exact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i && !(fixed_cap_i && fmt_fp16_i) && !fmt_420_i
        && (ratio_luma_h_i != RATIO_ONE)
        |=> mode_o != 3'd0);
endmodule

// File: tb/scl_mode_sel_tb_top.sv
module scl_mode_sel_tb_top;
    localparam int unsigned RW  = 22;
    localparam logic [RW-1:0] ONE = 22'h80000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load = 1'b0;
    logic cap = 1'b0, fp16 = 1'b0, f420 = 1'b0, vid = 1'b0, force_s = 1'b0;
    logic [RW-1:0] r_lh = '0, r_lv = '0, r_ch = '0, r_cv = '0;
    logic [2:0] mode;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    scl_mode_sel dut_i (
        .clk_i(clk), .rst_ni(rst_n), .load_i(load),
        .fixed_cap_i(cap), .fmt_fp16_i(fp16), .fmt_420_i(f420),
        .fmt_video_i(vid), .force_scale_i(force_s),
        .ratio_luma_h_i(r_lh), .ratio_luma_v_i(r_lv),
        .ratio_chroma_h_i(r_ch), .ratio_chroma_v_i(r_cv),
        .mode_o(mode)
    );

    function automatic logic [RW-1:0] pick(int idx);
        case (idx)
            0: return ONE;
            1: return ONE + 22'd1;
            2: return ONE - 22'd1;
            default: return ONE * 2;
        endcase
    endfunction

    // Priority model built from the requirements; also names the deciding rule
    function automatic logic [2:0] model(output string tag);
        bit lu, cu;
        lu = (r_lh == ONE) && (r_lv == ONE);
        cu = (r_ch == ONE) && (r_cv == ONE);
        if (cap && fp16) begin tag = "R2"; return 3'd6; end
        if (lu && cu && !force_s) begin tag = (fp16 ? "R3" : "R4"); return 3'd0; end
        if (!f420) begin tag = (fp16 ? "R3" : "R5"); return vid ? 3'd2 : 3'd1; end
        if (lu) begin tag = "R6"; return 3'd4; end
        if (cu) begin tag = "R7"; return 3'd5; end
        tag = "R7";
        return 3'd3;
    endfunction

    task automatic check(string req, logic [2:0] act, logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: mode actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load_and_check(string note);
        logic [2:0] exp;
        string tag;
        exp = model(tag);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        check({tag, note}, mode, exp);
        check("R1", {2'b00, mode == 3'd7}, 3'd0);
        // R9: inputs move without a strobe, the mode must stay
        f420 = ~f420; force_s = ~force_s; cap = ~cap; r_lh = r_lh + 22'd7;
        @(negedge clk);
        check("R9", mode, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run incomplete actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", mode, 3'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", mode, 3'd0);

        // R8 directed: one LSB off unity on a single ratio
        cap = 0; fp16 = 0; f420 = 0; vid = 0; force_s = 0;
        r_lh = ONE - 22'd1; r_lv = ONE; r_ch = ONE; r_cv = ONE;
        load_and_check(" R8 lsb-below");
        cap = 0; fp16 = 0; f420 = 0; vid = 1; force_s = 0;
        r_lh = ONE; r_lv = ONE; r_ch = ONE + 22'd1; r_cv = ONE;
        load_and_check(" R8 lsb-above");

        // Sweep of every flag combination and ratio class
        for (int f = 0; f < 32; f++) begin
            for (int r = 0; r < 256; r++) begin
                cap = f[0]; fp16 = f[1]; f420 = f[2]; vid = f[3]; force_s = f[4];
                r_lh = pick(r & 3);
                r_lv = pick((r >> 2) & 3);
                r_ch = pick((r >> 4) & 3);
                r_cv = pick((r >> 6) & 3);
                load_and_check("");
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule